// File: doc/BRIEF.md
# I2C Status Flags and Interrupt Source

This block holds the bus-busy and arbitration-lost status of an I2C controller and presents the interrupt-source code that software reads to find out why the controller interrupted. It takes one-cycle pulses from the bus monitor (START seen, STOP seen, arbitration lost), a start-request strobe from the mode logic, the module-enable bit that takes the controller out of its soft reset, and a plain register bus that carries a debug-read qualifier. From these it keeps its flags, drives clear strobes back into the mode register, and raises an interrupt request.

Bus-busy follows START and STOP only while the module is enabled. While the module is held in soft reset, bus-busy keeps its last value. Arbitration-lost is set by a lost contest or by a start attempt on a busy bus. It is cleared by a write-one, by a normal read of the interrupt-source register that returns its code, or by the soft reset. A debugger read does not clear it.

Top module: `i2cStatTop`

## Requirements
- R1: After the asynchronous reset `rstN` is released, `busBusy`, `arbLost`, `intReq` and `intCode` are all 0.
- R2: With `modEnable`=1, `startDet` sets `busBusy` at the next edge and `stopDet` clears it. If both pulse in the same cycle, `busBusy` becomes 1.
- R3: With `modEnable`=0, `startDet` and `stopDet` have no effect and `busBusy` keeps its value.
- R4: With `modEnable`=1, an `arbLostDet` pulse sets `arbLost` at the next edge.
- R5: With `modEnable`=1, `startReq` sets `arbLost` when `busBusy` is 1 and leaves it unchanged when `busBusy` is 0.
- R6: `mstClr` and `stpClr` are 1 exactly in the cycles where a set event for `arbLost` is applied, so the mode bits clear at the same edge where `arbLost` becomes 1.
- R7: A write to address 0 (status) with data bit 0 at 1 clears `arbLost`. With bit 0 at 0 the write has no effect.
- R8: A read at address 1 (interrupt source) with `dbgRd`=0 that returns code 3'b001 clears `arbLost`. The same read with `dbgRd`=1 leaves it set.
- R9: While `modEnable`=0, `arbLost` is cleared at the next edge and no set event is accepted.
- R10: `regRdData` at address 1 is `{13'b0, intCode}`, where `intCode` is 3'b001 while `arbLost`=1 and 3'b000 otherwise. At address 0 it reads bit 0 = `arbLost`, bit 1 = `busBusy`, and all other bits 0. Writes to address 1 have no effect.
- R11: When a set event and a clear event (write-one or read-clear) meet in one cycle, `arbLost` becomes 1.
- R12: `intReq` in cycle n+1 equals `arbLost && alIntEn` in cycle n. It therefore drops one cycle after the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| modEnable | input | 1 | Module out of soft reset |
| startDet | input | 1 | START condition detected pulse |
| stopDet | input | 1 | STOP condition detected pulse |
| arbLostDet | input | 1 | Arbitration contest lost pulse |
| startReq | input | 1 | Request to start a transfer as master |
| alIntEn | input | 1 | Interrupt enable for arbitration-lost |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| dbgRd | input | 1 | Marks the read as a debugger access |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` |
| busBusy | output | 1 | Bus-busy flag |
| arbLost | output | 1 | Arbitration-lost flag |
| mstClr | output | 1 | Clear strobe for the master bit |
| stpClr | output | 1 | Clear strobe for the stop bit |
| intCode | output | 3 | Pending interrupt code |
| intReq | output | 1 | Interrupt request |

## Verification
Bus-busy is driven with isolated START and STOP pulses, with both in one cycle, and with pulses while the module is disabled. These cases separate edge tracking, the collision rule and the freeze during soft reset. Arbitration-lost is set by a lost contest and by a start request, first on an idle bus and then on a busy one, which shows whether the busy check is present. It is cleared in turn by write-one, write-zero, a normal read, a debug read and the soft reset, so each clear path is checked on its own. A set that meets a clear in the same cycle confirms the priority rule, and the interrupt line is followed across a clear to confirm its one-cycle lag.

// File: rtl/i2cStatPkg.sv
package i2cStatPkg;
  typedef struct packed {
    logic bbSet;
    logic bbClr;
    logic alSet;
    logic alClr;
    logic alReset;
  } flagStrobeT;
endpackage

// File: rtl/i2cStatCtrl.sv
module i2cStatCtrl
  import i2cStatPkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int CODE_W = 3,
  parameter int STATUS_ADDR = 0,
  parameter int ISRC_ADDR = 1,
  parameter int AL_BIT = 0,
  parameter int AL_CODE = 1
) (
  input  logic              modEnable,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              arbLostDet,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              dbgRd,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              busBusy,
  input  logic [CODE_W-1:0] intCode,
  output flagStrobeT        strobe,
  output logic              mstClr,
  output logic              stpClr
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] ISRC_A = ADDR_W'(ISRC_ADDR);
  localparam logic [CODE_W-1:0] AL_C = CODE_W'(AL_CODE);
  localparam logic [DATA_W-1:0] AL_MASK = DATA_W'(1) << AL_BIT;

  logic lostEvt, busyStartEvt, setEvt;
  logic writeOneClr, readClr;
  logic unusedWrBits;

  // Any bit other than the flag's own is write-ignored.
  assign unusedWrBits = ^(regWrData & ~AL_MASK);

  assign lostEvt      = modEnable && arbLostDet;
  assign busyStartEvt = modEnable && startReq && busBusy;
  assign setEvt       = lostEvt || busyStartEvt;

  assign writeOneClr = regWrEn && (regAddr == STAT_A) && regWrData[AL_BIT];
  assign readClr     = regRdEn && !dbgRd && (regAddr == ISRC_A) && (intCode == AL_C);

  always_comb begin
    strobe.bbSet   = modEnable && startDet;
    strobe.bbClr   = modEnable && stopDet && !startDet;
    strobe.alSet   = setEvt;
    strobe.alClr   = writeOneClr || readClr;
    strobe.alReset = !modEnable;
  end

  // The mode register samples these at the same edge the flag is set.
  assign mstClr = setEvt;
  assign stpClr = setEvt;
endmodule

// File: rtl/i2cStatData.sv
module i2cStatData
  import i2cStatPkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int CODE_W = 3,
  parameter int STATUS_ADDR = 0,
  parameter int ISRC_ADDR = 1,
  parameter int AL_BIT = 0,
  parameter int BB_BIT = 1,
  parameter int AL_CODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobeT        strobe,
  input  logic              alIntEn,
  input  logic [ADDR_W-1:0] regAddr,
  output logic              busBusy,
  output logic              arbLost,
  output logic [CODE_W-1:0] intCode,
  output logic              intReq,
  output logic [DATA_W-1:0] regRdData
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] ISRC_A = ADDR_W'(ISRC_ADDR);
  localparam logic [CODE_W-1:0] AL_C = CODE_W'(AL_CODE);

  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] isrcWord;

  // Bus-busy: no soft-reset term, so it freezes while the module is disabled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busBusy <= 1'b0;
    else if (strobe.bbSet) busBusy <= 1'b1;
    else if (strobe.bbClr) busBusy <= 1'b0;
  end

  // Arbitration-lost: soft reset first, then set over clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) arbLost <= 1'b0;
    else if (strobe.alReset) arbLost <= 1'b0;
    else if (strobe.alSet) arbLost <= 1'b1;
    else if (strobe.alClr) arbLost <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intReq <= 1'b0;
    else intReq <= arbLost && alIntEn;
  end

  assign intCode = arbLost ? AL_C : '0;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : gStatusBits
    if (gi == AL_BIT) begin : gAl
      assign statusWord[gi] = arbLost;
    end else if (gi == BB_BIT) begin : gBb
      assign statusWord[gi] = busBusy;
    end else begin : gZero
      assign statusWord[gi] = 1'b0;
    end
  end

  assign isrcWord = {{(DATA_W-CODE_W){1'b0}}, intCode};

  always_comb begin
    if (regAddr == STAT_A) regRdData = statusWord;
    else if (regAddr == ISRC_A) regRdData = isrcWord;
    else regRdData = '0;
  end
endmodule

// File: rtl/i2cStatTop.sv
module i2cStatTop
  import i2cStatPkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int CODE_W = 3,
  parameter int STATUS_ADDR = 0,
  parameter int ISRC_ADDR = 1,
  parameter int AL_BIT = 0,
  parameter int BB_BIT = 1,
  parameter int AL_CODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modEnable,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              arbLostDet,
  input  logic              startReq,
  input  logic              alIntEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              dbgRd,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              busBusy,
  output logic              arbLost,
  output logic              mstClr,
  output logic              stpClr,
  output logic [CODE_W-1:0] intCode,
  output logic              intReq
);
  flagStrobeT strobe;

  i2cStatCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
    .STATUS_ADDR(STATUS_ADDR), .ISRC_ADDR(ISRC_ADDR),
    .AL_BIT(AL_BIT), .AL_CODE(AL_CODE)
  ) u_ctrl (
    .modEnable(modEnable), .startDet(startDet), .stopDet(stopDet),
    .arbLostDet(arbLostDet), .startReq(startReq), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .dbgRd(dbgRd),
    .regWrData(regWrData), .busBusy(busBusy), .intCode(intCode),
    .strobe(strobe), .mstClr(mstClr), .stpClr(stpClr)
  );

  i2cStatData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
    .STATUS_ADDR(STATUS_ADDR), .ISRC_ADDR(ISRC_ADDR),
    .AL_BIT(AL_BIT), .BB_BIT(BB_BIT), .AL_CODE(AL_CODE)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .alIntEn(alIntEn),
    .regAddr(regAddr), .busBusy(busBusy), .arbLost(arbLost),
    .intCode(intCode), .intReq(intReq), .regRdData(regRdData)
  );
endmodule

// File: rtl/i2cStatChecker.sv
module i2cStatChecker #(
  parameter int ADDR_W = 2,
  parameter int ISRC_ADDR = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              modEnable,
  input logic              startDet,
  input logic              arbLostDet,
  input logic              alIntEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic              dbgRd,
  input logic              busBusy,
  input logic              arbLost,
  input logic              mstClr,
  input logic              intReq
);
  localparam logic [ADDR_W-1:0] ISRC_A = ADDR_W'(ISRC_ADDR);

  assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modEnable && startDet) |=> busBusy);

  assert_bb_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    !modEnable |=> $stable(busBusy));

  assert_lost_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modEnable && arbLostDet) |=> arbLost);

  assert_strobe_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    mstClr |=> arbLost);

  assert_dbg_read_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modEnable && arbLost && regRdEn && dbgRd && !regWrEn && regAddr == ISRC_A) |=> arbLost);

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    !modEnable |=> !arbLost);

  assert_irq_on_R12: assert property (@(posedge clk) disable iff (!rstN)
    (arbLost && alIntEn) |=> intReq);

  assert_irq_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(arbLost && alIntEn) |=> !intReq);
endmodule

bind i2cStatTop i2cStatChecker #(.ADDR_W(ADDR_W), .ISRC_ADDR(ISRC_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .modEnable(modEnable), .startDet(startDet),
  .arbLostDet(arbLostDet), .alIntEn(alIntEn), .regAddr(regAddr),
  .regWrEn(regWrEn), .regRdEn(regRdEn), .dbgRd(dbgRd), .busBusy(busBusy),
  .arbLost(arbLost), .mstClr(mstClr), .intReq(intReq)
);

// File: tb/test_i2cStatTop.sv
module test_i2cStatTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modEnable = 1'b0, startDet = 1'b0, stopDet = 1'b0, arbLostDet = 1'b0;
  logic startReq = 1'b0, alIntEn = 1'b0, regWrEn = 1'b0, regRdEn = 1'b0, dbgRd = 1'b0;
  logic [1:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic busBusy, arbLost, mstClr, stpClr, intReq;
  logic [2:0] intCode;

  int checks = 0;
  int errors = 0;
  int mBB = 0, mAL = 0, mIrq = 0;

  always #4 clk = ~clk;

  i2cStatTop i_i2cStatTop (
    .clk(clk), .rstN(rstN), .modEnable(modEnable), .startDet(startDet),
    .stopDet(stopDet), .arbLostDet(arbLostDet), .startReq(startReq),
    .alIntEn(alIntEn), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .dbgRd(dbgRd), .regWrData(regWrData), .regRdData(regRdData),
    .busBusy(busBusy), .arbLost(arbLost), .mstClr(mstClr), .stpClr(stpClr),
    .intCode(intCode), .intReq(intReq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int modelSet();
    return (modEnable && (arbLostDet || (startReq && mBB != 0))) ? 1 : 0;
  endfunction

  function automatic int modelRead();
    if (regAddr == 2'd0) return mAL + 2 * mBB;
    if (regAddr == 2'd1) return mAL;
    return 0;
  endfunction

  // Compare everything against the model, then advance one clock.
  task automatic tick();
    int setE, clrE;
    #1;
    check("R2 busBusy", busBusy, mBB);
    check("R4 arbLost", arbLost, mAL);
    check("R6 mstClr", mstClr, modelSet());
    check("R6 stpClr", stpClr, modelSet());
    check("R10 intCode", intCode, mAL);
    check("R10 regRdData", regRdData, modelRead());
    check("R12 intReq", intReq, mIrq);
    @(posedge clk);
    setE = modelSet();
    clrE = ((regWrEn && regAddr == 2'd0 && regWrData[0]) ||
            (regRdEn && !dbgRd && regAddr == 2'd1 && mAL != 0)) ? 1 : 0;
    mIrq = (mAL != 0 && alIntEn) ? 1 : 0;
    if (!modEnable) mAL = 0;
    else if (setE != 0) mAL = 1;
    else if (clrE != 0) mAL = 0;
    if (modEnable) begin
      if (startDet) mBB = 1;
      else if (stopDet) mBB = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    startDet = 0; stopDet = 0; arbLostDet = 0; startReq = 0;
    regWrEn = 0; regRdEn = 0; dbgRd = 0; regWrData = '0; regAddr = 2'd0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R1 busBusy", busBusy, 0);
    check("R1 arbLost", arbLost, 0);
    check("R1 intReq", intReq, 0);
    check("R1 intCode", intCode, 0);
    @(negedge clk);

    modEnable = 1; tick();
    // R2: start, stop, both
    startDet = 1; tick(); idle(); check("R2 start", busBusy, 1);
    stopDet = 1; tick(); idle(); check("R2 stop", busBusy, 0);
    startDet = 1; stopDet = 1; tick(); idle(); check("R2 both", busBusy, 1);
    stopDet = 1; tick(); idle();
    // R3: frozen while disabled
    modEnable = 0; startDet = 1; tick(); idle(); check("R3 start ignored", busBusy, 0);
    modEnable = 1; startDet = 1; tick(); idle();
    modEnable = 0; stopDet = 1; tick(); idle(); check("R3 stop ignored", busBusy, 1);
    modEnable = 1; stopDet = 1; tick(); idle();
    // R4 and R10
    alIntEn = 1;
    arbLostDet = 1; tick(); idle(); check("R4 set", arbLost, 1);
    regAddr = 2'd1; #1 check("R10 isrc code", regRdData, 1);
    // R8 debug read keeps
    regRdEn = 1; dbgRd = 1; tick(); idle(); check("R8 debug read", arbLost, 1);
    check("R12 irq high", intReq, 1);
    // R8 normal read clears
    regAddr = 2'd1; regRdEn = 1; tick(); idle(); check("R8 normal read", arbLost, 0);
    check("R12 irq lags clear", intReq, 1);
    tick(); check("R12 irq dropped", intReq, 0);
    // R7 write-zero then write-one
    arbLostDet = 1; tick(); idle();
    regWrEn = 1; regWrData = 16'hFFFE; tick(); idle(); check("R7 write zero", arbLost, 1);
    regWrEn = 1; regWrData = 16'h0001; tick(); idle(); check("R7 write one", arbLost, 0);
    // R10 write to isrc ignored
    regAddr = 2'd1; regWrEn = 1; regWrData = 16'hFFFF; tick(); idle();
    regAddr = 2'd1; #1 check("R10 isrc write ignored", regRdData, 0);
    // R5 start request
    startReq = 1; #1 check("R6 no strobe idle bus", mstClr, 0);
    tick(); idle(); check("R5 idle bus", arbLost, 0);
    startDet = 1; tick(); idle();
    startReq = 1; #1 check("R6 strobe", mstClr, 1);
    check("R6 stop strobe", stpClr, 1);
    tick(); idle(); check("R5 busy bus", arbLost, 1);
    regAddr = 2'd0; #1 check("R10 status word", regRdData, 3);
    // R9 soft reset
    modEnable = 0; tick(); idle(); check("R9 cleared", arbLost, 0);
    arbLostDet = 1; #1 check("R9 no strobe", mstClr, 0);
    tick(); idle(); check("R9 blocked", arbLost, 0);
    modEnable = 1; tick();
    // R11 set meets clear
    arbLostDet = 1; tick(); idle();
    arbLostDet = 1; regWrEn = 1; regWrData = 16'h0001; tick(); idle();
    check("R11 set wins write", arbLost, 1);
    arbLostDet = 1; regRdEn = 1; regAddr = 2'd1; tick(); idle();
    check("R11 set wins read", arbLost, 1);
    alIntEn = 0; tick(); tick(); check("R12 disabled", intReq, 0);
    repeat (4) tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule